// File: doc/BRIEF.md
# Floating-Point Compare Exception Flag Unit

This unit takes two IEEE-754 single-precision operands and reports, as a 32-bit integer vector, the exception flags that an ordered less-than comparison of them would raise. It does not return the comparison outcome. It uses the same bit layout as the processor's IEEE status flags, so software can merge the vector into that status word or test it directly. The unit itself never touches a global status register.

Operands with a zero exponent and a nonzero fraction are flushed to zero before the comparison, and the flush is reported in its own flag. A NaN on either side raises the invalid flag. A mode input selects the greater-than form. That form is the same computation with the two operands exchanged.

The result appears one cycle after an accepted request. A destination register inside the unit is written only when the guard bit that comes with the request is 1. Otherwise the register keeps its earlier contents, and the write-enable output stays low.

Top module: `fp_cmp_flags`

## Requirements
- R1: A request accepted with `in_valid` high at a clock edge produces `out_valid` high for exactly one cycle after that edge; `out_valid` is low otherwise.
- R2: If either operand is a NaN (exponent field bits 30:23 all ones, fraction bits 22:0 nonzero, either sign), bit 4 (value 0x10, invalid) of the written result is 1.
- R3: If either operand is denormal (exponent field zero, fraction nonzero, either sign), it is treated as zero, and bit 5 (value 0x20, input flushed) of the written result is 1. An operand that is already ±0 does not set this bit.
- R4: A denormal on one side and a NaN on the other give the result 0x30.
- R5: Operands that are all finite normals, zeros or infinities of either sign give the result 0x00000000. This includes +INF against -INF and +INF against itself.
- R6: Result bits 31:6 and bits 3:0 (overflow, underflow, inexact, divide-by-zero, output-flushed) are always 0.
- R7: A request with `guard` = 1 writes the result register and pulses `wr_en` together with `out_valid`. A request with `guard` = 0 leaves `result` unchanged and keeps `wr_en` low.
- R8: With `gt_mode` = 1 the operands are exchanged before the flag computation. For every operand pair the flags equal those of the less-than form.
- R9: While `rst_n` is low, `out_valid`, `wr_en` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| gt_mode | input | 1 | 1 selects the greater-than form (operands exchanged) |
| guard | input | 1 | Least significant bit of the guard register; 1 enables the write |
| src_a | input | 32 | First operand, single precision |
| src_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Result cycle marker, one cycle after the request |
| wr_en | output | 1 | Destination write pulse |
| result | output | 32 | Destination register holding the flag vector |

## Verification
The hardest case to reach from the ports is a request with `guard` = 0 that follows one with `guard` = 1. To show the hold, the register must already contain a distinctive value such as 0x30, and the dropped request must use operands that would write a different value. The bench sweeps every pair from a set of operand classes (signed zeros, normals, infinities, quiet and signalling NaNs, signed denormals) in both modes. It then places guarded-off requests directly after written ones whose expected values differ, so that any leak through the guard shows up at `result`.

// File: rtl/fpcf_pkg.sv
package fpcf_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;

    // Flag bit positions, matching the processor status flag layout
    localparam int FLG_DBZ = 0;
    localparam int FLG_INX = 1;
    localparam int FLG_UNF = 2;
    localparam int FLG_OVF = 3;
    localparam int FLG_INV = 4;
    localparam int FLG_IFZ = 5;
    localparam int FLG_OFZ = 6;
    localparam int FLG_W   = 7;

    typedef struct packed {
        logic is_nan;
        logic is_den;
    } op_class_t;
endpackage

// File: rtl/fpcf_classify.sv
module fpcf_classify
    import fpcf_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int M_W = MAN_W,
    localparam int OP_W = 1 + E_W + M_W
) (
    input  logic [OP_W-1:0] op,
    output op_class_t       cls
);
    logic [E_W-1:0] exp_f;
    logic [M_W-1:0] man_f;

    always_comb begin
        exp_f      = op[OP_W-2 -: E_W];
        man_f      = op[M_W-1:0];
        cls.is_nan = (&exp_f) && (|man_f);
        cls.is_den = (~|exp_f) && (|man_f);
    end
endmodule

// File: rtl/fpcf_encode.sv
module fpcf_encode
    import fpcf_pkg::*;
#(
    parameter int OUT_W = WORD_W
) (
    input  op_class_t        cls_l,
    input  op_class_t        cls_r,
    output logic [OUT_W-1:0] flags
);
    logic [FLG_W-1:0] fv;

    always_comb begin
        fv          = '0;
        // Flushed operands compare as zero; an ordered compare of zeros,
        // normals or infinities raises nothing further.
        fv[FLG_IFZ] = cls_l.is_den | cls_r.is_den;
        // Ordered less-than on any NaN is an invalid operation
        fv[FLG_INV] = cls_l.is_nan | cls_r.is_nan;
        flags       = {{(OUT_W-FLG_W){1'b0}}, fv};
    end
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fpcf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         gt_mode,
    input  logic         guard,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         out_valid,
    output logic         wr_en,
    output logic [W-1:0] result
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic         vld;
        logic         we;
        logic [W-1:0] res;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] ops [NOPS];
    op_class_t    cls [NOPS];
    logic [W-1:0] flag_vec;

    // Greater-than form: exchange operands ahead of the less-than flags
    always_comb begin
        ops[0] = gt_mode ? src_b : src_a;
        ops[1] = gt_mode ? src_a : src_b;
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fpcf_classify #(.E_W(EXP_W), .M_W(W-1-EXP_W)) u_cls (
            .op  (ops[i]),
            .cls (cls[i])
        );
    end

    fpcf_encode #(.OUT_W(W)) u_enc (
        .cls_l (cls[0]),
        .cls_r (cls[1]),
        .flags (flag_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = in_valid & guard;
        if (in_valid && guard) begin
            st_d.res = flag_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.we;
    assign result    = st_q.res;

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));
    // R7
    we_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> $stable(result));
    // R2
    inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past((&src_a[W-2 -: EXP_W] && |src_a[W-2-EXP_W:0]) ||
                        (&src_b[W-2 -: EXP_W] && |src_b[W-2-EXP_W:0])))
        |-> result[FLG_INV]);
    // R3
    ifz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past((~|src_a[W-2 -: EXP_W] && |src_a[W-2-EXP_W:0]) ||
                        (~|src_b[W-2 -: EXP_W] && |src_b[W-2-EXP_W:0])))
        |-> result[FLG_IFZ]);
    // R6
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (result[W-1:FLG_OFZ] == '0 && result[FLG_OVF:FLG_DBZ] == '0));
endmodule

// File: tb/fp_cmp_flags_bench.sv
module fp_cmp_flags_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic        gt_mode = 0;
    logic        guard = 0;
    logic [31:0] src_a = 0;
    logic [31:0] src_b = 0;
    logic        out_valid, wr_en;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_reg = 0;
    logic [31:0] pool [10];

    always #2 clk = ~clk;

    fp_cmp_flags u_fp_cmp_flags (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gt_mode(gt_mode),
        .guard(guard), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .wr_en(wr_en), .result(result)
    );

    function automatic logic [31:0] expect_flags(logic [31:0] a, logic [31:0] b);
        logic [31:0] f = 0;
        int ea = a[30:23], eb = b[30:23];
        int ma = a[22:0],  mb = b[22:0];
        if ((ea == 255 && ma != 0) || (eb == 255 && mb != 0)) f = f + 32'h10;
        if ((ea == 0 && ma != 0) || (eb == 0 && mb != 0))     f = f + 32'h20;
        return f;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] a, logic [31:0] b, logic gm, logic g, string req);
        logic [31:0] e;
        @(negedge clk);
        src_a = a; src_b = b; gt_mode = gm; guard = g; in_valid = 1;
        e = expect_flags(a, b);
        if (g) model_reg = e;
        @(negedge clk);
        in_valid = 0;
        check({req, " R1 valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " R7 wr_en"}, {31'd0, wr_en}, {31'd0, g});
        check(req, result, model_reg);
        check({req, " R6 spare"}, result & 32'hFFFF_FFCF, 32'd0);
    endtask

    initial begin
        pool[0] = 32'h0000_0000; pool[1] = 32'h8000_0000;
        pool[2] = 32'h3F80_0000; pool[3] = 32'h4040_0000;
        pool[4] = 32'h7F80_0000; pool[5] = 32'hFF80_0000;
        pool[6] = 32'hFFFF_FFFF; pool[7] = 32'h7F80_0001;
        pool[8] = 32'h0040_0000; pool[9] = 32'h8000_0001;

        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 valid", {31'd0, out_valid}, 0);
        check("R9 wr_en", {31'd0, wr_en}, 0);
        check("R9 result", result, 0);
        rst_n = 1;

        // R5 named cases
        issue(32'h4040_0000, 32'h0000_0000, 0, 1, "R5 3<0");
        issue(32'h4040_0000, 32'h4040_0000, 0, 1, "R5 3<3");
        issue(32'h3F80_0000, 32'h4040_0000, 0, 1, "R5 1<3");
        issue(32'h7F80_0000, 32'hFF80_0000, 0, 1, "R5 inf<-inf");
        issue(32'h7F80_0000, 32'h7F80_0000, 0, 1, "R5 inf<inf");
        issue(32'h4040_0000, 32'hFFFF_FFFF, 0, 1, "R2 qnan");
        issue(32'h3F80_0000, 32'h0040_0000, 0, 1, "R3 denorm");
        issue(32'h0040_0000, 32'hFFFF_FFFF, 0, 1, "R4 den+nan");
        check("R4 value", result, 32'h30);

        // R8 sweep: both modes, all class pairs
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    issue(pool[i], pool[j], m[0], 1, m ? "R8 gt sweep" : "R2/R3 lt sweep");

        // R7 guard off after a distinctive write
        issue(32'h8000_0001, 32'h7F80_0001, 0, 1, "R7 setup");
        issue(32'h3F80_0000, 32'h4040_0000, 0, 0, "R7 hold");
        issue(32'h0040_0000, 32'h3F80_0000, 1, 0, "R7 hold gt");
        check("R7 held", result, 32'h30);
        issue(32'h3F80_0000, 32'h4040_0000, 0, 1, "R7 write");
        @(negedge clk);
        check("R1 drop", {31'd0, out_valid}, 0);
        check("R7 idle", {31'd0, wr_en}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule